// File: doc/BRIEF.md
# Posted Write Bridge Controller

This block sits between an on-chip bus master and a simplified PCI-style master port. It carries write bursts from the chip to targets on the outbound side. The internal side offers one word per cycle. It flags the opening word of a burst and marks the final word. The bridge answers each word with an accept, a retry or a disconnect. Accepted words are held in a local buffer. Once the burst is closed, the bridge replays the words toward the target with an incrementing address, one word per ready handshake.

In the default posted mode the internal write is reported complete as soon as its last word is buffered. Any new internal burst is refused with retry until the replay has ended. When the mode bit is set, the bridge instead withholds the completion report until the outbound write ends, and then reports success or failure. The bridge cuts bursts so that the replay never exceeds the word limit and never leaves an aligned address window. An abort from the target or from the master side discards the rest of the buffer. It sets a sticky status bit on both the internal-side and the host-side status register, and each unmasked status bit drives its side's interrupt.

Top module: `pwb_bridge`

## Requirements
- R1: After reset, pm_valid, ib_done, ib_err and both interrupts are 0, and both status registers read 0.
- R2: With the mode bit sampled as 0 (posted), every offered word of a burst is acknowledged in its own cycle. ib_done pulses high with ib_err low in the cycle after the final word is accepted, while the outbound replay is still pending.
- R3: From the cycle after a burst closes until the cycle after its outbound write ends, an opening word gets ib_retry high and ib_ack low. After that window, an opening word is accepted again.
- R4: The replay presents the buffered words in order. pm_addr starts at the first word's address and rises by 4 bytes per word. pm_last is high only on the final word, and a word advances only on a cycle where pm_ready is high.
- R5: A burst is cut at MAX_BURST (16) words: the 16th word is acknowledged together with ib_disc when ib_last is low.
- R6: A burst is cut at the end of a WIN_BYTES (64) byte aligned window. The word whose address bits [5:2] are all ones is acknowledged with ib_disc when ib_last is low, so no replayed address leaves the window.
- R7: A target abort (pm_tabort) during the replay sets status bit 0 in both st_int and st_host. A master abort (pm_mabort) sets bit 1 in both. If both arrive together, only bit 0 is set.
- R8: irq_int is high when any st_int bit has its mask_int bit at 0, and irq_host behaves likewise with mask_host. A mask bit of 1 blocks that source.
- R9: Writing 1 to a clr_int or clr_host bit clears that status bit at the next edge. An abort that sets the same bit in the same cycle wins over the clear.
- R10: An abort ends the replay. pm_valid is low from the next cycle, the remaining buffered words are never presented, and the next opening word is accepted and replayed with its own data.
- R11: With the mode bit sampled as 1 (held), ib_done stays low until the outbound write ends. It then pulses for one cycle, with ib_err high if the write was aborted and low otherwise.
- R12: The mode bit is sampled only on the opening word of a burst. Changing it in mid-burst does not change how that burst is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hold | input | 1 | Mode bit: 0 posted, 1 held until the outbound write completes |
| ib_valid | input | 1 | Internal word offered |
| ib_first | input | 1 | Offered word opens a burst |
| ib_last | input | 1 | Offered word is the master's final word |
| ib_addr | input | AW | Byte address of the opening word |
| ib_data | input | DW | Write data word |
| ib_ack | output | 1 | Word accepted into the buffer |
| ib_retry | output | 1 | Opening word refused, try again later |
| ib_disc | output | 1 | Word accepted, but the burst is cut here |
| ib_done | output | 1 | One-cycle completion report for the internal write |
| ib_err | output | 1 | Completion carries an abort (held mode only) |
| pm_valid | output | 1 | Outbound word presented |
| pm_addr | output | AW | Outbound word byte address |
| pm_data | output | DW | Outbound word data |
| pm_last | output | 1 | Final outbound word of the burst |
| pm_ready | input | 1 | Target takes the presented word |
| pm_tabort | input | 1 | Target abort, ends the outbound write |
| pm_mabort | input | 1 | Master abort, ends the outbound write |
| clr_int | input | 2 | Write-1-to-clear for st_int |
| clr_host | input | 2 | Write-1-to-clear for st_host |
| mask_int | input | 2 | Interrupt mask for st_int bits, 1 blocks |
| mask_host | input | 2 | Interrupt mask for st_host bits, 1 blocks |
| st_int | output | 2 | Internal-side abort status: bit 0 target, bit 1 master |
| st_host | output | 2 | Host-side abort status: bit 0 target, bit 1 master |
| irq_int | output | 1 | Interrupt to the internal processor |
| irq_host | output | 1 | Interrupt to the host |

## Verification
The bench probes an opening word in the very cycle after a posted burst closes. A bridge that freed itself at buffering time would accept that word and corrupt the pending replay. It starts one burst in the middle of a 64-byte window and another on a wider-window instance. This tells apart a cut at the window edge from a cut at the word limit, which a design mixing them up would confuse. It aborts a replay part-way while a clear hits the same status bit. A design that kept stale words would replay old data in the next burst, and one that let the clear win would lose the abort record. It also flips the mode bit in mid-burst and aborts in held mode. A bridge that sampled the mode late, or reported success too early, would pulse completion in the wrong cycle or with the wrong error flag.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

   typedef enum logic [1:0] {
      IB_IDLE = 2'd0,
      IB_FILL = 2'd1,
      IB_WAIT = 2'd2
   } ib_state_e;

   localparam int SIDES   = 2;
   localparam int SIDE_IN = 0;
   localparam int SIDE_HS = 1;
   localparam int BIT_TGT = 0;
   localparam int BIT_MST = 1;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pwb_fifo.sv
module pwb_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [DW-1:0]                din,
   input  logic                         pop,
   input  logic                         flush,
   output logic [DW-1:0]                dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty
);
   import pwb_pkg::*;

   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW    = $clog2(DEPTH + 1);
   localparam bit  POW2  = is_pow2(DEPTH);

   initial begin
      a_cfg_depth: assert (DEPTH >= 2) else $error("pwb_fifo: DEPTH must be at least 2");
   end

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             full;

   generate
      if (POW2) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty = (count == '0);
   assign full  = (count == CW'(DEPTH));
   assign dout  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !full) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push && !full) wr_ptr <= wr_nxt;
         if (pop && !empty) rd_ptr <= rd_nxt;
         case ({push && !full, pop && !empty})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full)
      else $error("buffer overflow");

   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty)
      else $error("buffer underflow");

endmodule

// File: rtl/pwb_inbound.sv
module pwb_inbound #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int MAX_BURST = 16,
   parameter int WIN_BYTES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_hold,
   input  logic          ib_valid,
   input  logic          ib_first,
   input  logic          ib_last,
   input  logic [AW-1:0] ib_addr,
   input  logic [DW-1:0] ib_data,
   input  logic          ob_fin,
   input  logic          ob_abort,
   output logic          ib_ack,
   output logic          ib_retry,
   output logic          ib_disc,
   output logic          ib_done,
   output logic          ib_err,
   output logic          push,
   output logic [DW-1:0] push_data,
   output logic          burst_rdy,
   output logic [AW-1:0] base_addr
);
   import pwb_pkg::*;

   localparam int BYTES    = DW / 8;
   localparam int BYTE_LSB = $clog2(BYTES);
   localparam int WIN_LSB  = $clog2(WIN_BYTES);
   localparam int CNT_W    = $clog2(MAX_BURST + 1);

   ib_state_e      state;
   logic [CNT_W-1:0] cnt, cnt_nxt;
   logic [AW-1:0]  cur_addr, word_addr;
   logic           hold_q, hold_eff;
   logic           take, win_end, cut, close, fin_hold;

   always_comb begin
      take      = ib_valid && (((state == IB_IDLE) && ib_first) || (state == IB_FILL));
      word_addr = (state == IB_IDLE) ? ib_addr : cur_addr;
      win_end   = &word_addr[WIN_LSB-1:BYTE_LSB];
      cnt_nxt   = cnt + 1'b1;
      cut       = (cnt_nxt == CNT_W'(MAX_BURST)) || win_end;
      close     = take && (ib_last || cut);
      hold_eff  = (state == IB_IDLE) ? cfg_hold : hold_q;
      fin_hold  = (state == IB_WAIT) && ob_fin && hold_q;
   end

   assign ib_ack    = take;
   assign ib_disc   = take && cut && !ib_last;
   assign ib_retry  = ib_valid && ib_first && (state == IB_WAIT);
   assign push      = take;
   assign push_data = ib_data;
   assign burst_rdy = (state == IB_WAIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= IB_IDLE;
         cnt       <= '0;
         cur_addr  <= '0;
         base_addr <= '0;
         hold_q    <= 1'b0;
         ib_done   <= 1'b0;
         ib_err    <= 1'b0;
      end else begin
         ib_done <= (close && !hold_eff) || fin_hold;
         ib_err  <= fin_hold && ob_abort;
         case (state)
            IB_IDLE: begin
               if (take) begin
                  base_addr <= ib_addr;
                  cur_addr  <= ib_addr + AW'(BYTES);
                  cnt       <= CNT_W'(1);
                  hold_q    <= cfg_hold;
                  state     <= close ? IB_WAIT : IB_FILL;
               end
            end
            IB_FILL: begin
               if (take) begin
                  cur_addr <= cur_addr + AW'(BYTES);
                  cnt      <= cnt_nxt;
                  if (close) state <= IB_WAIT;
               end
            end
            IB_WAIT: begin
               if (ob_fin) begin
                  state <= IB_IDLE;
                  cnt   <= '0;
               end
            end
            default: state <= IB_IDLE;
         endcase
      end
   end

   a_r5_burst_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MAX_BURST))
      else $error("burst count beyond limit");

   a_r3_retry_excl: assert property (@(posedge clk) disable iff (!rst_n)
      ib_retry |-> (!ib_ack && !ib_disc))
      else $error("retry together with accept");

   a_r3_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == IB_WAIT && !ob_fin) |=> (state == IB_WAIT))
      else $error("left wait before outbound end");

   a_r2_posted_done: assert property (@(posedge clk) disable iff (!rst_n)
      (close && !hold_eff) |=> (ib_done && !ib_err))
      else $error("posted completion missing");

   a_r11_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (state == IB_WAIT && hold_q) |-> !ib_done)
      else $error("held write reported early");

endmodule

// File: rtl/pwb_outbound.sv
module pwb_outbound #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int MAX_BURST = 16,
   parameter int WIN_BYTES = 64
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           burst_rdy,
   input  logic [AW-1:0]                  base_addr,
   input  logic [DW-1:0]                  fifo_dout,
   input  logic [$clog2(MAX_BURST+1)-1:0] fifo_count,
   input  logic                           fifo_empty,
   input  logic                           pm_ready,
   input  logic                           pm_tabort,
   input  logic                           pm_mabort,
   output logic                           pm_valid,
   output logic [AW-1:0]                  pm_addr,
   output logic [DW-1:0]                  pm_data,
   output logic                           pm_last,
   output logic                           pop,
   output logic                           flush,
   output logic                           ob_fin,
   output logic                           ob_abort,
   output logic                           ob_tgt,
   output logic                           ob_mst
);
   localparam int BYTES    = DW / 8;
   localparam int BYTE_LSB = $clog2(BYTES);
   localparam int WIN_LSB  = $clog2(WIN_BYTES);
   localparam int CW       = $clog2(MAX_BURST + 1);

   logic [CW-1:0] idx;

   always_comb begin
      pm_valid = burst_rdy && !fifo_empty;
      pm_data  = fifo_dout;
      pm_last  = (fifo_count == CW'(1));
      pm_addr  = base_addr + (AW'(idx) << BYTE_LSB);
      ob_abort = pm_valid && (pm_tabort || pm_mabort);
      ob_tgt   = pm_valid && pm_tabort;
      ob_mst   = pm_valid && pm_mabort && !pm_tabort;
      pop      = pm_valid && pm_ready && !ob_abort;
      flush    = ob_abort;
      ob_fin   = ob_abort || (pop && pm_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      idx <= '0;
      else if (ob_fin) idx <= '0;
      else if (pop)    idx <= idx + 1'b1;
   end

   a_r6_same_window: assert property (@(posedge clk) disable iff (!rst_n)
      pm_valid |-> (pm_addr[AW-1:WIN_LSB] == base_addr[AW-1:WIN_LSB]))
      else $error("replay left the address window");

   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !pm_last) |=> (pm_valid && pm_addr == $past(pm_addr) + AW'(BYTES)))
      else $error("replay address did not step");

   a_r10_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      ob_abort |=> !pm_valid)
      else $error("replay continued after abort");

endmodule

// File: rtl/pwb_status.sv
module pwb_status (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                set_tgt,
   input  logic                                set_mst,
   input  logic [pwb_pkg::SIDES-1:0][1:0]      clr,
   input  logic [pwb_pkg::SIDES-1:0][1:0]      mask,
   output logic [pwb_pkg::SIDES-1:0][1:0]      st,
   output logic [pwb_pkg::SIDES-1:0]           irq
);
   import pwb_pkg::*;

   logic [1:0] setv;
   assign setv[BIT_TGT] = set_tgt;
   assign setv[BIT_MST] = set_mst;

   generate
      for (genvar g = 0; g < SIDES; g++) begin : g_side
         always_ff @(posedge clk) begin
            if (!rst_n) st[g] <= '0;
            else        st[g] <= (st[g] & ~clr[g]) | setv;
         end

         assign irq[g] = |(st[g] & ~mask[g]);

         a_r7_set_tgt: assert property (@(posedge clk) disable iff (!rst_n)
            set_tgt |=> st[g][BIT_TGT])
            else $error("target abort not recorded");

         a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g][BIT_MST] && !set_mst) |=> !st[g][BIT_MST])
            else $error("clear did not take");
      end
   endgenerate

endmodule

// File: rtl/pwb_bridge.sv
module pwb_bridge #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int MAX_BURST = 16,
   parameter int WIN_BYTES = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_hold,
   input  logic          ib_valid,
   input  logic          ib_first,
   input  logic          ib_last,
   input  logic [AW-1:0] ib_addr,
   input  logic [DW-1:0] ib_data,
   output logic          ib_ack,
   output logic          ib_retry,
   output logic          ib_disc,
   output logic          ib_done,
   output logic          ib_err,
   output logic          pm_valid,
   output logic [AW-1:0] pm_addr,
   output logic [DW-1:0] pm_data,
   output logic          pm_last,
   input  logic          pm_ready,
   input  logic          pm_tabort,
   input  logic          pm_mabort,
   input  logic [1:0]    clr_int,
   input  logic [1:0]    clr_host,
   input  logic [1:0]    mask_int,
   input  logic [1:0]    mask_host,
   output logic [1:0]    st_int,
   output logic [1:0]    st_host,
   output logic          irq_int,
   output logic          irq_host
);
   import pwb_pkg::*;

   localparam int CW = $clog2(MAX_BURST + 1);

   initial begin
      a_cfg_dw:  assert (DW >= 16 && is_pow2(DW)) else $error("DW must be a power of two, at least 16");
      a_cfg_win: assert (is_pow2(WIN_BYTES) && WIN_BYTES > DW / 8) else $error("WIN_BYTES must be a power of two above the word size");
      a_cfg_max: assert (MAX_BURST >= 2) else $error("MAX_BURST must be at least 2");
      a_cfg_aw:  assert (AW > $clog2(WIN_BYTES)) else $error("AW too narrow for the window");
   end

   logic          push, pop, flush, burst_rdy, fifo_empty;
   logic [DW-1:0] push_data, fifo_dout;
   logic [CW-1:0] fifo_count;
   logic [AW-1:0] base_addr;
   logic          ob_fin, ob_abort, ob_tgt, ob_mst;
   logic [SIDES-1:0][1:0] clr_v, mask_v, st_v;
   logic [SIDES-1:0]      irq_v;

   pwb_inbound #(.AW(AW), .DW(DW), .MAX_BURST(MAX_BURST), .WIN_BYTES(WIN_BYTES)) u_in (
      .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold),
      .ib_valid(ib_valid), .ib_first(ib_first), .ib_last(ib_last),
      .ib_addr(ib_addr), .ib_data(ib_data),
      .ob_fin(ob_fin), .ob_abort(ob_abort),
      .ib_ack(ib_ack), .ib_retry(ib_retry), .ib_disc(ib_disc),
      .ib_done(ib_done), .ib_err(ib_err),
      .push(push), .push_data(push_data),
      .burst_rdy(burst_rdy), .base_addr(base_addr)
   );

   pwb_fifo #(.DW(DW), .DEPTH(MAX_BURST)) u_buf (
      .clk(clk), .rst_n(rst_n), .push(push), .din(push_data),
      .pop(pop), .flush(flush), .dout(fifo_dout),
      .count(fifo_count), .empty(fifo_empty)
   );

   pwb_outbound #(.AW(AW), .DW(DW), .MAX_BURST(MAX_BURST), .WIN_BYTES(WIN_BYTES)) u_out (
      .clk(clk), .rst_n(rst_n), .burst_rdy(burst_rdy), .base_addr(base_addr),
      .fifo_dout(fifo_dout), .fifo_count(fifo_count), .fifo_empty(fifo_empty),
      .pm_ready(pm_ready), .pm_tabort(pm_tabort), .pm_mabort(pm_mabort),
      .pm_valid(pm_valid), .pm_addr(pm_addr), .pm_data(pm_data), .pm_last(pm_last),
      .pop(pop), .flush(flush), .ob_fin(ob_fin), .ob_abort(ob_abort),
      .ob_tgt(ob_tgt), .ob_mst(ob_mst)
   );

   assign clr_v[SIDE_IN]  = clr_int;
   assign clr_v[SIDE_HS]  = clr_host;
   assign mask_v[SIDE_IN] = mask_int;
   assign mask_v[SIDE_HS] = mask_host;

   pwb_status u_st (
      .clk(clk), .rst_n(rst_n), .set_tgt(ob_tgt), .set_mst(ob_mst),
      .clr(clr_v), .mask(mask_v), .st(st_v), .irq(irq_v)
   );

   assign st_int   = st_v[SIDE_IN];
   assign st_host  = st_v[SIDE_HS];
   assign irq_int  = irq_v[SIDE_IN];
   assign irq_host = irq_v[SIDE_HS];

   a_r3_no_accept_in_replay: assert property (@(posedge clk) disable iff (!rst_n)
      pm_valid |-> !ib_ack)
      else $error("accepted a word during replay");

   a_r10_abort_empties: assert property (@(posedge clk) disable iff (!rst_n)
      ob_abort |=> fifo_empty)
      else $error("buffer kept data after abort");

endmodule

// File: tb/pwb_bridge_bench.sv
`timescale 1ns/1ps
module pwb_bridge_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_hold = 1'b0;
   logic        ib_valid = 1'b0, ib_first = 1'b0, ib_last = 1'b0;
   logic [31:0] ib_addr = '0, ib_data = '0;
   logic        ib_ack, ib_retry, ib_disc, ib_done, ib_err;
   logic        pm_valid, pm_last;
   logic [31:0] pm_addr, pm_data;
   logic        pm_ready = 1'b0, pm_tabort = 1'b0, pm_mabort = 1'b0;
   logic [1:0]  clr_int = '0, clr_host = '0, mask_int = '0, mask_host = '0;
   logic [1:0]  st_int, st_host;
   logic        irq_int, irq_host;

   logic        w_valid = 1'b0, w_first = 1'b0, w_last = 1'b0;
   logic [31:0] w_addr = '0, w_data = '0;
   logic        w_ack, w_retry, w_disc, w_done, w_err, w_pm_valid, w_pm_last;
   logic [31:0] w_pm_addr, w_pm_data;
   logic [1:0]  w_st_int, w_st_host;
   logic        w_irq_int, w_irq_host;

   int vectors = 0;
   int errs = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   pwb_bridge u_pwb_bridge (
      .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold),
      .ib_valid(ib_valid), .ib_first(ib_first), .ib_last(ib_last),
      .ib_addr(ib_addr), .ib_data(ib_data),
      .ib_ack(ib_ack), .ib_retry(ib_retry), .ib_disc(ib_disc),
      .ib_done(ib_done), .ib_err(ib_err),
      .pm_valid(pm_valid), .pm_addr(pm_addr), .pm_data(pm_data), .pm_last(pm_last),
      .pm_ready(pm_ready), .pm_tabort(pm_tabort), .pm_mabort(pm_mabort),
      .clr_int(clr_int), .clr_host(clr_host), .mask_int(mask_int), .mask_host(mask_host),
      .st_int(st_int), .st_host(st_host), .irq_int(irq_int), .irq_host(irq_host)
   );

   pwb_bridge #(.WIN_BYTES(256)) u_pwb_bridge_wide (
      .clk(clk), .rst_n(rst_n), .cfg_hold(1'b0),
      .ib_valid(w_valid), .ib_first(w_first), .ib_last(w_last),
      .ib_addr(w_addr), .ib_data(w_data),
      .ib_ack(w_ack), .ib_retry(w_retry), .ib_disc(w_disc),
      .ib_done(w_done), .ib_err(w_err),
      .pm_valid(w_pm_valid), .pm_addr(w_pm_addr), .pm_data(w_pm_data), .pm_last(w_pm_last),
      .pm_ready(1'b1), .pm_tabort(1'b0), .pm_mabort(1'b0),
      .clr_int(2'b00), .clr_host(2'b00), .mask_int(2'b00), .mask_host(2'b00),
      .st_int(w_st_int), .st_host(w_st_host), .irq_int(w_irq_int), .irq_host(w_irq_host)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // Offer n words; the bridge is expected to cut at index disc_at (-1: none).
   task automatic send(input logic [31:0] a, input int n, input int disc_at,
                       input logic [31:0] seed, input bit flip, input string tag);
      for (int i = 0; i < n; i++) begin
         ib_valid = 1'b1; ib_first = (i == 0); ib_last = (i == n - 1);
         ib_addr = a + 32'(4 * i); ib_data = seed + 32'(i);
         #1;
         chk({tag, " ack"}, ib_ack, 1'b1);
         chk({tag, " retry"}, ib_retry, 1'b0);
         chk({tag, " disc"}, ib_disc, (i == disc_at));
         step();
         if (flip && i == 0) cfg_hold = ~cfg_hold;
         if (i == disc_at) break;
      end
      ib_valid = 1'b0; ib_first = 1'b0; ib_last = 1'b0;
   endtask

   // Drain n words; abort_kind 1 target, 2 master, 3 both at index abort_at.
   task automatic drain(input logic [31:0] a, input int n, input logic [31:0] seed,
                        input int abort_at, input int abort_kind, input string tag);
      for (int i = 0; i < n; i++) begin
         pm_ready = 1'b1;
         if (i == abort_at) begin
            pm_tabort = abort_kind[0];
            pm_mabort = abort_kind[1];
         end
         #1;
         chk({tag, " valid"}, pm_valid, 1'b1);
         chk({tag, " addr"}, pm_addr, a + 32'(4 * i));
         chk({tag, " data"}, pm_data, seed + 32'(i));
         if (i != abort_at) chk({tag, " last"}, pm_last, (i == n - 1));
         step();
         if (i == abort_at) break;
      end
      pm_ready = 1'b0; pm_tabort = 1'b0; pm_mabort = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      chk("R1 pm_valid", pm_valid, 1'b0);
      chk("R1 done", ib_done, 1'b0);
      chk("R1 err", ib_err, 1'b0);
      chk("R1 st_int", st_int, 2'b00);
      chk("R1 st_host", st_host, 2'b00);
      chk("R1 irq", {irq_int, irq_host}, 2'b00);
   endtask

   task automatic t_posted();
      cfg_hold = 1'b0;
      send(32'h1000, 4, -1, 32'hA0, 1'b0, "R2 posted");
      chk("R2 done after buffering", ib_done, 1'b1);
      chk("R2 no error", ib_err, 1'b0);
      chk("R4 replay pending", pm_valid, 1'b1);
      ib_valid = 1'b1; ib_first = 1'b1; ib_last = 1'b1; ib_addr = 32'h1800; ib_data = 32'hDEAD;
      #1;
      chk("R3 retry while outstanding", ib_retry, 1'b1);
      chk("R3 no ack while outstanding", ib_ack, 1'b0);
      step();
      ib_valid = 1'b0; ib_first = 1'b0; ib_last = 1'b0;
      chk("R2 done is one pulse", ib_done, 1'b0);
      chk("R4 stall without ready", pm_data, 32'hA0);
      drain(32'h1000, 4, 32'hA0, -1, 0, "R4 replay");
      chk("R4 replay ended", pm_valid, 1'b0);
      send(32'h1100, 1, -1, 32'hB0, 1'b0, "R3 accepted after completion");
      drain(32'h1100, 1, 32'hB0, -1, 0, "R4 single");
   endtask

   task automatic t_window();
      send(32'h3030, 8, 3, 32'hC0, 1'b0, "R6 window cut");
      drain(32'h3030, 4, 32'hC0, -1, 0, "R6 window replay");
      chk("R6 nothing beyond window", pm_valid, 1'b0);
   endtask

   task automatic t_sixteen();
      send(32'h2000, 20, 15, 32'h100, 1'b0, "R5 aligned sixteen");
      drain(32'h2000, 16, 32'h100, -1, 0, "R4 sixteen replay");
   endtask

   task automatic t_cap_wide();
      for (int i = 0; i < 20; i++) begin
         w_valid = 1'b1; w_first = (i == 0); w_last = (i == 19);
         w_addr = 32'h2010 + 32'(4 * i); w_data = 32'h200 + 32'(i);
         #1;
         chk("R5 cap ack", w_ack, 1'b1);
         chk("R5 cap disc", w_disc, (i == 15));
         step();
         if (i == 15) break;
      end
      w_valid = 1'b0; w_first = 1'b0; w_last = 1'b0;
      chk("R5 capped burst completes", w_done, 1'b1);
      chk("R5 capped replay starts", w_pm_valid, 1'b1);
      chk("R5 capped replay addr", w_pm_addr, 32'h2010);
      repeat (17) step();
      chk("R5 capped replay drained", w_pm_valid, 1'b0);
   endtask

   task automatic t_abort();
      send(32'h4000, 3, -1, 32'h300, 1'b0, "R10 setup");
      clr_int = 2'b00;
      pm_ready = 1'b1;
      #1;
      chk("R4 first word", pm_data, 32'h300);
      step();
      pm_tabort = 1'b1; clr_int = 2'b01;
      #1;
      chk("R10 second word shown", pm_data, 32'h301);
      step();
      pm_tabort = 1'b0; pm_ready = 1'b0; clr_int = 2'b00;
      chk("R10 replay stops after abort", pm_valid, 1'b0);
      chk("R7 target abort internal, R9 set beats clear", st_int, 2'b01);
      chk("R7 target abort host", st_host, 2'b01);
      chk("R8 irq_int", irq_int, 1'b1);
      chk("R8 irq_host", irq_host, 1'b1);
      send(32'h4100, 1, -1, 32'h400, 1'b0, "R10 new burst accepted");
      drain(32'h4100, 1, 32'h400, -1, 0, "R10 old data discarded");
      chk("R10 nothing left", pm_valid, 1'b0);
   endtask

   task automatic t_mask_clear();
      mask_int = 2'b01;
      #1;
      chk("R8 masked internal", irq_int, 1'b0);
      chk("R8 host unaffected", irq_host, 1'b1);
      mask_host = 2'b10;
      #1;
      chk("R8 other mask bit", irq_host, 1'b1);
      mask_host = 2'b01;
      #1;
      chk("R8 masked host", irq_host, 1'b0);
      mask_int = 2'b00; mask_host = 2'b00;
      clr_int = 2'b01;
      step();
      clr_int = 2'b00;
      chk("R9 clear internal", st_int, 2'b00);
      chk("R9 host untouched", st_host, 2'b01);
      chk("R8 irq_int after clear", irq_int, 1'b0);
      clr_host = 2'b01;
      step();
      clr_host = 2'b00;
      chk("R9 clear host", st_host, 2'b00);
      chk("R8 irq_host after clear", irq_host, 1'b0);
   endtask

   task automatic t_hold();
      cfg_hold = 1'b1;
      send(32'h5000, 2, -1, 32'h500, 1'b0, "R11 held");
      chk("R11 no early done", ib_done, 1'b0);
      repeat (3) step();
      chk("R11 still waiting", ib_done, 1'b0);
      drain(32'h5000, 2, 32'h500, -1, 0, "R11 replay");
      chk("R11 done at completion", ib_done, 1'b1);
      chk("R11 success", ib_err, 1'b0);
      step();
      chk("R11 done one pulse", ib_done, 1'b0);
      send(32'h5100, 2, -1, 32'h600, 1'b0, "R11 held abort");
      drain(32'h5100, 2, 32'h600, 0, 2, "R11 master abort");
      chk("R11 done after abort", ib_done, 1'b1);
      chk("R11 error on abort", ib_err, 1'b1);
      chk("R7 master abort internal", st_int, 2'b10);
      chk("R7 master abort host", st_host, 2'b10);
      clr_int = 2'b10; clr_host = 2'b10;
      step();
      clr_int = 2'b00; clr_host = 2'b00;
      chk("R9 clear master bits", {st_int, st_host}, 4'b0000);
      send(32'h5200, 1, -1, 32'h700, 1'b0, "R7 both setup");
      drain(32'h5200, 1, 32'h700, 0, 3, "R7 both aborts");
      chk("R7 target wins", st_int, 2'b01);
      clr_int = 2'b11; clr_host = 2'b11;
      step();
      clr_int = 2'b00; clr_host = 2'b00;
   endtask

   task automatic t_mode_latch();
      cfg_hold = 1'b0;
      send(32'h6000, 2, -1, 32'h800, 1'b1, "R12 posted then flip");
      chk("R12 posted kept", ib_done, 1'b1);
      drain(32'h6000, 2, 32'h800, -1, 0, "R12 replay a");
      chk("R12 no second report", ib_done, 1'b0);
      cfg_hold = 1'b1;
      send(32'h6100, 2, -1, 32'h900, 1'b1, "R12 held then flip");
      chk("R12 held kept", ib_done, 1'b0);
      drain(32'h6100, 2, 32'h900, -1, 0, "R12 replay b");
      chk("R12 held report", ib_done, 1'b1);
      cfg_hold = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_posted();
      t_window();
      t_sixteen();
      t_cap_wide();
      t_abort();
      t_mask_clear();
      t_hold();
      t_mode_latch();
      step();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!finished) begin
         errs++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
         $finish;
      end
   end

endmodule